// File: doc/BRIEF.md
# Quadrant-Split Unsigned Multiplier with Per-Quadrant Approximation

This block multiplies two unsigned operands of width 2k by cutting each into a high and a low k-bit half and forming the four k×k products of those halves. The products are placed at their binary weight and summed into a 4k-bit result. The low-by-low product carries no shift, the two mixed products move up by k, and the high-by-high product moves up by 2k.

A four-bit approximation mask chooses, for each quadrant on its own, between an exact sub-multiplier and a cheaper truncated one. The truncated unit drops the lowest columns of its partial-product array. The high-by-high quadrant carries most of the result's weight, so it is always exact. Any error is therefore confined to the lower-significance quadrants. An error-tolerant datapath, such as a filter or an inference engine, can set the mask to trade accuracy for logic. With an all-zero mask it gets an exact product.

The datapath takes new operands every cycle. The result comes out of an output register. An optional register between the sub-multipliers and the final sum adds one more cycle.

Top module: `split_mul`

## Requirements
- R1: Operands `op_a` and `op_b` are unsigned, 2·HALF_W bits wide, and `product` is 4·HALF_W bits wide. With defaults (HALF_W=8), 0xFFFF × 0xFFFF gives 0xFFFE0001.
- R2: When `approx_mask` is 4'b0000, `product` equals `op_a` × `op_b` exactly, for every operand pair.
- R3: Mask bit positions pick quadrants. Bit 0 approximates low(A)·low(B) at weight 2^0. Bit 1 approximates low(A)·high(B) at weight 2^HALF_W. Bit 2 approximates high(A)·low(B) at weight 2^HALF_W. A cleared bit leaves its quadrant exact.
- R4: An approximated quadrant equals the sum over all partial-product bits x[i]&y[j] with i+j ≥ TRUNC_COLS of 2^(i+j). Every column below TRUNC_COLS is dropped. TRUNC_COLS defaults to HALF_W/2.
- R5: Mask bit 3 has no effect. The high(A)·high(B) quadrant is always exact, so mask 4'b1000 gives the exact product and 4'b1111 gives the same result as 4'b0111.
- R6: `product` is never above the exact product. Its shortfall is below TRUNC_COLS·2^TRUNC_COLS·(1 + 2^(HALF_W+1)).
- R7: `product` reflects the operands and mask presented 1 + PIPE_SUB cycles earlier, which is two cycles with the default PIPE_SUB=1. A new set of operands is accepted every cycle.
- R8: While `rst_n` is low, `product` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | 2·HALF_W | Multiplicand, unsigned |
| op_b | input | 2·HALF_W | Multiplier, unsigned |
| approx_mask | input | 4 | Per-quadrant approximation select (bit 3 ignored) |
| product | output | 4·HALF_W | Product, registered |

## Verification
The assertions assume the operands and mask are known, non-X values at every clock edge after reset. They also assume HALF_W is small enough (at most 16) for the error bound to fit in 64 bits. The checker compares the output against its own delay line of the inputs, and it arms only after enough cycles since reset have passed to fill that line. The stimulus drives every input on the falling edge from a fixed seed, so values are always defined at the sampling edge. Reset is applied only in whole-cycle windows, and the checker's delay line restarts after each one.

// File: rtl/smul_pkg.sv
package smul_pkg;
   localparam int NUM_QUAD = 4;

   typedef enum logic [1:0] {
      QD_LL = 2'd0,
      QD_LH = 2'd1,
      QD_HL = 2'd2,
      QD_HH = 2'd3
   } quad_e;

   function automatic int quad_shift(input int q, input int half_w);
      case (q)
         0:       return 0;
         3:       return 2 * half_w;
         default: return half_w;
      endcase
   endfunction
endpackage

// File: rtl/smul_sub_exact.sv
module smul_sub_exact #(
   parameter int HALF_W = 8,
   localparam int SUB_W = 2 * HALF_W
) (
   input  logic [HALF_W-1:0] x,
   input  logic [HALF_W-1:0] y,
   output logic [SUB_W-1:0]  p
);
   assign p = SUB_W'(x) * SUB_W'(y);
endmodule

// File: rtl/smul_sub_trunc.sv
module smul_sub_trunc #(
   parameter int HALF_W    = 8,
   parameter int TRUNC_COLS = HALF_W / 2,
   localparam int SUB_W = 2 * HALF_W
) (
   input  logic [HALF_W-1:0] x,
   input  logic [HALF_W-1:0] y,
   output logic [SUB_W-1:0]  p
);
   if (TRUNC_COLS < 0 || TRUNC_COLS > SUB_W - 1) begin : g_bad_cols
      $error("smul_sub_trunc: TRUNC_COLS out of range");
   end

   // Column-kept partial-product array: only bits of weight >= TRUNC_COLS
   always_comb begin
      p = '0;
      for (int i = 0; i < HALF_W; i++) begin
         for (int j = 0; j < HALF_W; j++) begin
            if (i + j >= TRUNC_COLS) begin
               p = p + (SUB_W'(x[i] & y[j]) << (i + j));
            end
         end
      end
   end
endmodule

// File: rtl/smul_quad.sv
module smul_quad #(
   parameter int HALF_W       = 8,
   parameter int TRUNC_COLS   = HALF_W / 2,
   parameter bit ALLOW_APPROX = 1'b1,
   localparam int SUB_W = 2 * HALF_W
) (
   input  logic [HALF_W-1:0] x,
   input  logic [HALF_W-1:0] y,
   input  logic              approx_en,
   output logic [SUB_W-1:0]  p
);
   logic [SUB_W-1:0] p_exact;

   smul_sub_exact #(.HALF_W(HALF_W)) u_exact (
      .x (x),
      .y (y),
      .p (p_exact)
   );

   if (ALLOW_APPROX) begin : g_sel
      logic [SUB_W-1:0] p_trunc;
      smul_sub_trunc #(.HALF_W(HALF_W), .TRUNC_COLS(TRUNC_COLS)) u_trunc (
         .x (x),
         .y (y),
         .p (p_trunc)
      );
      assign p = approx_en ? p_trunc : p_exact;
   end else begin : g_exact_only
      logic approx_en_unused;
      assign approx_en_unused = approx_en;
      assign p = p_exact;
   end
endmodule

// File: rtl/smul_accum.sv
module smul_accum
   import smul_pkg::*;
#(
   parameter int HALF_W = 8,
   localparam int SUB_W  = 2 * HALF_W,
   localparam int PROD_W = 4 * HALF_W,
   localparam int MID_W  = SUB_W + 1
) (
   input  logic [SUB_W-1:0]  sub_p [NUM_QUAD],
   output logic [PROD_W-1:0] sum
);
   logic [MID_W-1:0]  cross_sum;
   logic [PROD_W-1:0] edge_pair;
   logic [PROD_W-1:0] cross_placed;

   // The two mixed quadrants share weight 2^HALF_W: add them once, place once
   assign cross_sum    = MID_W'(sub_p[QD_LH]) + MID_W'(sub_p[QD_HL]);
   // HH and LL do not overlap: concatenation places them at 2^(2k) and 2^0
   assign edge_pair    = {sub_p[QD_HH], sub_p[QD_LL]};
   assign cross_placed = PROD_W'(cross_sum) << quad_shift(int'(QD_LH), HALF_W);
   assign sum          = edge_pair + cross_placed;
endmodule

// File: rtl/split_mul.sv
module split_mul
   import smul_pkg::*;
#(
   parameter int HALF_W     = 8,
   parameter int TRUNC_COLS = HALF_W / 2,
   parameter bit PIPE_SUB   = 1'b1,
   localparam int OP_W   = 2 * HALF_W,
   localparam int SUB_W  = 2 * HALF_W,
   localparam int PROD_W = 4 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OP_W-1:0]   op_a,
   input  logic [OP_W-1:0]   op_b,
   input  logic [3:0]        approx_mask,
   output logic [PROD_W-1:0] product
);
   if (HALF_W < 2) begin : g_bad_half
      $error("split_mul: HALF_W must be at least 2");
   end
   if (TRUNC_COLS < 0 || TRUNC_COLS > SUB_W - 1) begin : g_bad_trunc
      $error("split_mul: TRUNC_COLS must lie in 0..2*HALF_W-1");
   end

   logic [HALF_W-1:0] a_half [2];
   logic [HALF_W-1:0] b_half [2];
   logic [SUB_W-1:0]  sub_d  [NUM_QUAD];
   logic [SUB_W-1:0]  sub_q  [NUM_QUAD];
   logic [PROD_W-1:0] sum_d;

   assign a_half[0] = op_a[HALF_W-1:0];
   assign a_half[1] = op_a[OP_W-1:HALF_W];
   assign b_half[0] = op_b[HALF_W-1:0];
   assign b_half[1] = op_b[OP_W-1:HALF_W];

   // Quadrant q takes A half (q>>1) and B half (q&1)
   for (genvar q = 0; q < NUM_QUAD; q++) begin : g_quad
      smul_quad #(
         .HALF_W       (HALF_W),
         .TRUNC_COLS   (TRUNC_COLS),
         .ALLOW_APPROX (q != int'(QD_HH))
      ) u_quad (
         .x         (a_half[q / 2]),
         .y         (b_half[q % 2]),
         .approx_en (approx_mask[q]),
         .p         (sub_d[q])
      );
   end

   if (PIPE_SUB) begin : g_sub_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int q = 0; q < NUM_QUAD; q++) sub_q[q] <= '0;
         end else begin
            for (int q = 0; q < NUM_QUAD; q++) sub_q[q] <= sub_d[q];
         end
      end
   end else begin : g_sub_wire
      always_comb begin
         for (int q = 0; q < NUM_QUAD; q++) sub_q[q] = sub_d[q];
      end
   end

   smul_accum #(.HALF_W(HALF_W)) u_accum (
      .sub_p (sub_q),
      .sum   (sum_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) product <= '0;
      else        product <= sum_d;
   end
endmodule

// File: rtl/smul_checker.sv
module smul_checker #(
   parameter int HALF_W     = 8,
   parameter int TRUNC_COLS = HALF_W / 2,
   parameter bit PIPE_SUB   = 1'b1,
   localparam int OP_W   = 2 * HALF_W,
   localparam int PROD_W = 4 * HALF_W,
   localparam int LAT    = 1 + int'(PIPE_SUB)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [OP_W-1:0]   op_a,
   input logic [OP_W-1:0]   op_b,
   input logic [3:0]        approx_mask,
   input logic [PROD_W-1:0] product
);
   if (HALF_W > 16) begin : g_chk_limit
      $error("smul_checker: error bound needs HALF_W <= 16");
   end

   localparam longint ERR_BOUND =
      longint'(TRUNC_COLS) * (64'd1 << TRUNC_COLS) * (64'd1 + (64'd1 << (HALF_W + 1)));

   logic [PROD_W-1:0] exp_line [LAT];
   logic [3:0]        msk_line [LAT];
   logic [1:0]        fill;
   logic              armed;
   logic [PROD_W-1:0] exp_now;
   logic [PROD_W-1:0] shortfall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill <= '0;
         for (int s = 0; s < LAT; s++) begin
            exp_line[s] <= '0;
            msk_line[s] <= '0;
         end
      end else begin
         if (int'(fill) < LAT) fill <= fill + 2'd1;
         exp_line[0] <= PROD_W'(op_a) * PROD_W'(op_b);
         msk_line[0] <= approx_mask;
         for (int s = 1; s < LAT; s++) begin
            exp_line[s] <= exp_line[s-1];
            msk_line[s] <= msk_line[s-1];
         end
      end
   end

   assign armed     = (int'(fill) == LAT);
   assign exp_now   = exp_line[LAT-1];
   assign shortfall = exp_now - product;

   // R8: reset holds the result at zero
   a_r8_reset_zero: assert property (@(posedge clk) !rst_n |-> product == '0);

   // R2: all-exact mask reproduces the true product after the latency
   a_r2_exact_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && msk_line[LAT-1][2:0] == 3'b000) |-> product == exp_now);

   // R6: approximation only removes value
   a_r6_not_above: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> product <= exp_now);

   // R6: shortfall bounded by truncated columns
   a_r6_err_bound: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> 64'(shortfall) < ERR_BOUND);

   // R7: constant inputs give a constant result once the pipe has drained
   a_r7_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $stable(exp_now) && $stable(msk_line[LAT-1]) && $stable(op_a) && $stable(op_b))
      |=> $stable(product) || !armed);
endmodule

bind split_mul smul_checker #(
   .HALF_W     (HALF_W),
   .TRUNC_COLS (TRUNC_COLS),
   .PIPE_SUB   (PIPE_SUB)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .op_a        (op_a),
   .op_b        (op_b),
   .approx_mask (approx_mask),
   .product     (product)
);

// File: tb/sim_split_mul.sv
`timescale 1ns/1ps
module sim_split_mul;
   localparam int HALF_W = 8;
   localparam int TRUNC  = HALF_W / 2;
   localparam int OP_W   = 2 * HALF_W;
   localparam int PROD_W = 4 * HALF_W;
   localparam int LAT    = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [OP_W-1:0]   op_a = '0;
   logic [OP_W-1:0]   op_b = '0;
   logic [3:0]        approx_mask = '0;
   logic [PROD_W-1:0] product;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   int cycles = 0;

   logic [PROD_W-1:0] h_exp [LAT];
   logic [PROD_W-1:0] h_true [LAT];
   string             h_tag [LAT];
   bit                h_vld [LAT];

   always #2 clk = ~clk;

   split_mul #(.HALF_W(HALF_W), .TRUNC_COLS(TRUNC), .PIPE_SUB(1'b1)) u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .op_a        (op_a),
      .op_b        (op_b),
      .approx_mask (approx_mask),
      .product     (product)
   );

   // R4: truncated quadrant model
   function automatic logic [OP_W-1:0] trunc_mul(input logic [HALF_W-1:0] x,
                                                 input logic [HALF_W-1:0] y);
      logic [OP_W-1:0] s = '0;
      for (int i = 0; i < HALF_W; i++)
         for (int j = 0; j < HALF_W; j++)
            if (i + j >= TRUNC && x[i] && y[j]) s = s + (OP_W'(1) << (i + j));
      return s;
   endfunction

   // R3/R5: quadrant composition with mask
   function automatic logic [PROD_W-1:0] model(input logic [OP_W-1:0] a,
                                                input logic [OP_W-1:0] b,
                                                input logic [3:0] m);
      logic [HALF_W-1:0] al = a[HALF_W-1:0];
      logic [HALF_W-1:0] ah = a[OP_W-1:HALF_W];
      logic [HALF_W-1:0] bl = b[HALF_W-1:0];
      logic [HALF_W-1:0] bh = b[OP_W-1:HALF_W];
      logic [PROD_W-1:0] ll = m[0] ? PROD_W'(trunc_mul(al, bl)) : PROD_W'(al) * PROD_W'(bl);
      logic [PROD_W-1:0] lh = m[1] ? PROD_W'(trunc_mul(al, bh)) : PROD_W'(al) * PROD_W'(bh);
      logic [PROD_W-1:0] hl = m[2] ? PROD_W'(trunc_mul(ah, bl)) : PROD_W'(ah) * PROD_W'(bl);
      logic [PROD_W-1:0] hh = PROD_W'(ah) * PROD_W'(bh);
      return (hh << (2 * HALF_W)) + (lh << HALF_W) + (hl << HALF_W) + ll;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [PROD_W-1:0] act,
                        input logic [PROD_W-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic clear_hist();
      for (int s = 0; s < LAT; s++) h_vld[s] = 1'b0;
   endtask

   task automatic step(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b,
                       input logic [3:0] m, input string tag);
      @(negedge clk);
      if (h_vld[LAT-1]) begin
         check(product == h_exp[LAT-1], h_tag[LAT-1], product, h_exp[LAT-1]);
         check(product <= h_true[LAT-1], "R6 not above exact", product, h_true[LAT-1]);
      end
      for (int s = LAT - 1; s > 0; s--) begin
         h_exp[s] = h_exp[s-1]; h_true[s] = h_true[s-1];
         h_tag[s] = h_tag[s-1]; h_vld[s] = h_vld[s-1];
      end
      h_exp[0]  = model(a, b, m);
      h_true[0] = PROD_W'(a) * PROD_W'(b);
      h_tag[0]  = tag;
      h_vld[0]  = 1'b1;
      op_a = a; op_b = b; approx_mask = m;
   endtask

   task automatic flush();
      for (int s = 0; s < LAT; s++) step('0, '0, 4'b0000, "R2 flush zero");
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000 && !done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   initial begin : stim
      logic [OP_W-1:0] ra, rb;
      logic [3:0]      rm;
      void'($urandom(32'd2024));
      clear_hist();
      op_a = 16'hABCD; op_b = 16'h1234;
      repeat (3) @(negedge clk);
      check(product == '0, "R8 reset state", product, '0);
      rst_n = 1'b1;

      // R1 widths and corners, R2 exact
      step(16'hFFFF, 16'hFFFF, 4'b0000, "R1 max*max");
      step(16'h0000, 16'hFFFF, 4'b0000, "R2 zero operand");
      step(16'h8000, 16'h8000, 4'b0000, "R2 power of two");
      step(16'h0100, 16'h0001, 4'b0000, "R2 power of two low");
      step(16'hFFFF, 16'h0001, 4'b0000, "R2 max*one");
      // R3 each quadrant alone, R4 truncation
      step(16'h00FF, 16'h00FF, 4'b0001, "R3 bit0 low*low");
      step(16'h00FF, 16'hFF00, 4'b0010, "R3 bit1 lowA*highB");
      step(16'hFF00, 16'h00FF, 4'b0100, "R3 bit2 highA*lowB");
      step(16'h00FF, 16'hFF00, 4'b0001, "R3 bit0 leaves cross exact");
      step(16'h0003, 16'h0001, 4'b0001, "R4 column below cut dropped");
      step(16'h0010, 16'h0001, 4'b0001, "R4 column at cut kept");
      // R5 bit3 ignored
      step(16'hFFFF, 16'hFFFF, 4'b1000, "R5 bit3 alone exact");
      step(16'hFFFF, 16'hFFFF, 4'b1111, "R5 1111 same as 0111");
      step(16'hFFFF, 16'hFFFF, 4'b0111, "R6 all approx max");
      // R7 back-to-back distinct operands each cycle
      for (int k = 0; k < 6; k++)
         step(OP_W'(k * 16'h1111 + 1), OP_W'(16'hF0F0 - k), 4'(k), "R7 back to back");
      flush();

      for (int n = 0; n < 300; n++) begin
         ra = OP_W'($urandom); rb = OP_W'($urandom);
         step(ra, rb, 4'b0000, "R2 random exact");
      end
      for (int n = 0; n < 400; n++) begin
         ra = OP_W'($urandom); rb = OP_W'($urandom); rm = 4'($urandom);
         step(ra, rb, rm, "R4 random mask");
      end
      flush();

      // R8 mid-run reset
      step(16'hFFFF, 16'hFFFF, 4'b0000, "R2 before reset");
      @(negedge clk);
      rst_n = 1'b0;
      clear_hist();
      @(negedge clk);
      check(product == '0, "R8 mid-run reset", product, '0);
      rst_n = 1'b1;
      step(16'h1234, 16'h5678, 4'b0000, "R2 after reset");
      flush();

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule